// File: doc/BRIEF.md
# Dual-Bank Late-Select Load Path

This block is the read side of a direct-mapped, doubleword-wide data cache, reduced to the data path of a load. A load arrives as a base register value, an offset, a size code and a signed/unsigned flag. The line storage is split in two. One bank keeps the lines with an even line index and the other keeps the lines with an odd line index. Each bank works out its own row straight from the index fields of the two operands, without waiting for the carry out of the byte-offset bits. Both bank reads start in the request cycle.

The carry out of the three byte-offset bits resolves late, in parallel with the bank reads. Together with the parity of the index-field sum, it picks which of the two fetched doublewords is the addressed one. The addressed bytes are then shifted down and extended to 64 bits. A plain full-width adder runs alongside and presents the complete virtual address to the rest of the memory pipeline. A request whose byte offset is not a multiple of its size is flagged instead of being serviced. A simple write port loads whole lines into the banks.

Top module: `sadCacheRead`

## Requirements
- R1: `vaddr` equals `ldBase + ldOffset` modulo 2^32 in the same cycle, with no register on the way.
- R2: After a clock edge that samples `ldValid` high with an aligned request, `rdValid` is high for exactly the following cycle. After an edge that samples `ldValid` low, both `rdValid` and `rdMisalign` are low.
- R3: The data comes from line `(ldBase+ldOffset)[13:3]`, including the case where `ldBase[2:0]+ldOffset[2:0]` carries into bit 3 and selects the line after `ldBase[13:3]+ldOffset[13:3]`.
- R4: Line indices wrap modulo 2048, so a sum that carries past bit 13 reads line 0 upward again.
- R5: Bytes are little-endian within a line: byte k occupies bits 8k+7:8k. The result's least significant byte is byte `(ldBase+ldOffset)[2:0]` of the line.
- R6: `ldSize` codes 0, 1, 2 and 3 load 1, 2, 4 and 8 bytes.
- R7: With `ldSigned` = 1, the loaded field is sign-extended from its top bit to 64 bits. With `ldSigned` = 0, it is zero-extended.
- R8: A request whose byte offset is not a multiple of its size gives `rdMisalign` = 1, `rdValid` = 0 and `rdData` = 0 in the following cycle.
- R9: A write with `wrEn` = 1 stores `wrData` as line `wrIndex`, in the odd bank when `wrIndex[0]` = 1 and otherwise in the even bank. Later loads of that line return it, and the other lines are unchanged.
- R10: While `rstN` is low, `rdValid` and `rdMisalign` are low and `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Load request strobe |
| ldBase | input | 32 | Base register value |
| ldOffset | input | 32 | Offset added to the base |
| ldSize | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| ldSigned | input | 1 | 1 = sign-extend, 0 = zero-extend |
| vaddr | output | 32 | Full virtual address sum |
| wrEn | input | 1 | Line write strobe |
| wrIndex | input | 11 | Line index to write |
| wrData | input | 64 | Line data to write |
| rdValid | output | 1 | Load data valid |
| rdMisalign | output | 1 | Request was misaligned and not serviced |
| rdData | output | 64 | Extended load result |

## Verification
The hard corner is the late-select case. The low three bits must carry into bit 3, and the index-field sum may be either even or odd, which swaps the bank that wins. Wrap-around at line 2047 is a further variant of the same case. Random base and offset pairs seldom land on the top lines together with a low-bit carry. For that reason, directed loads place the base in the last line and add offsets with and without a low-bit carry, including negative offsets. The random loads are nudged to aligned sums most of the time, so that steering and extension are exercised across all sizes and byte positions. The remaining loads stay misaligned to exercise the flag.

// File: rtl/sadCachePkg.sv
package sadCachePkg;
  parameter int ADDR_W      = 32;
  parameter int LINE_BYTES  = 8;
  parameter int CACHE_BYTES = 16384;

  localparam int DATA_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W  = $clog2(LINES);
  localparam int ROW_W  = IDX_W - 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ldSizeT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request-side state this edge
    logic outValid;  // registered result is to be presented
  } ctrlStrobeT;

  // Carry-save row match: true when r+o lands on row l or on the row below it.
  // The bit-0 comparison is dropped on purpose.
  function automatic logic csMatch(input logic [IDX_W-1:0] r,
                                   input logic [IDX_W-1:0] o,
                                   input logic [IDX_W-1:0] l);
    logic [IDX_W-1:0] nl;
    logic [IDX_W-1:0] s;
    logic [IDX_W-1:0] c;
    nl = ~l;
    s  = r ^ o ^ nl;
    c[0] = 1'b0;
    for (int k = 1; k < IDX_W; k++) begin
      c[k] = (r[k-1] & o[k-1]) | (r[k-1] & nl[k-1]) | (o[k-1] & nl[k-1]);
    end
    return &(s[IDX_W-1:1] ^ c[IDX_W-1:1]);
  endfunction
endpackage

// File: rtl/sadBank.sv
module sadBank #(
  parameter int ROWS_W = 10,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ROWS_W-1:0] wrRow,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ROWS_W-1:0] rdRow,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ROWS_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrRow] <= wrData;
    if (rdEn) rdData <= store[rdRow];
  end
endmodule

// File: rtl/sadCtrl.sv
module sadCtrl
  import sadCachePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldValid,
  input  logic [1:0]       ldSize,
  input  logic [OFF_W-1:0] byteOff,
  output ctrlStrobeT       strobes,
  output logic             rdValid,
  output logic             rdMisalign
);
  logic validQ;
  logic misQ;
  logic misNow;
  logic [OFF_W-1:0] sizeMask;

  always_comb begin
    unique case (ldSizeT'(ldSize))
      SZ_BYTE: sizeMask = OFF_W'(0);
      SZ_HALF: sizeMask = OFF_W'(1);
      SZ_WORD: sizeMask = OFF_W'(3);
      default: sizeMask = OFF_W'(7);
    endcase
    misNow = |(byteOff & sizeMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      misQ   <= 1'b0;
    end else begin
      validQ <= ldValid;
      misQ   <= ldValid & misNow;
    end
  end

  assign strobes.capture  = ldValid;
  assign strobes.outValid = validQ & ~misQ;
  assign rdValid          = strobes.outValid;
  assign rdMisalign       = validQ & misQ;

  // R2
  aligned_serviced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && !misNow) |=> (rdValid && !rdMisalign));
  // R8
  misaligned_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && misNow) |=> (rdMisalign && !rdValid));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldValid |=> (!rdValid && !rdMisalign));
endmodule

// File: rtl/sadData.sv
module sadData
  import sadCachePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [ADDR_W-1:0] ldBase,
  input  logic [ADDR_W-1:0] ldOffset,
  input  logic [1:0]        ldSize,
  input  logic              ldSigned,
  output logic [ADDR_W-1:0] vaddr,
  output logic [OFF_W-1:0]  byteOff,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int NBANK = 2;

  logic [IDX_W-1:0] rIdx, oIdx, idxSum;
  logic [OFF_W:0]   lowSum;
  logic             lowCarry;
  logic [ROW_W-1:0] evenRow, oddRow;
  logic             selOdd;

  // full address for the rest of the pipe
  assign vaddr = ldBase + ldOffset;

  // index-field add without the byte-offset carry
  assign rIdx     = ldBase[OFF_W +: IDX_W];
  assign oIdx     = ldOffset[OFF_W +: IDX_W];
  assign idxSum   = rIdx + oIdx;
  assign lowSum   = {1'b0, ldBase[OFF_W-1:0]} + {1'b0, ldOffset[OFF_W-1:0]};
  assign lowCarry = lowSum[OFF_W];
  assign byteOff  = lowSum[OFF_W-1:0];

  // each bank takes whichever of idxSum, idxSum+1 has its parity
  assign oddRow  = idxSum[IDX_W-1:1];
  assign evenRow = idxSum[IDX_W-1:1] + ROW_W'(idxSum[0]);
  assign selOdd  = idxSum[0] ^ lowCarry;

  logic [DATA_W-1:0] bankQ [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sadBank #(.ROWS_W(ROW_W), .WORD_W(DATA_W)) u_bank (
      .clk   (clk),
      .wrEn  (wrEn && (wrIndex[0] == 1'(b))),
      .wrRow (wrIndex[IDX_W-1:1]),
      .wrData(wrData),
      .rdEn  (strobes.capture),
      .rdRow ((b == 1) ? oddRow : evenRow),
      .rdData(bankQ[b])
    );
  end

  // request-side state carried to the select stage
  logic             selOddQ;
  logic [OFF_W-1:0] byteOffQ;
  ldSizeT           sizeQ;
  logic             signedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selOddQ  <= 1'b0;
      byteOffQ <= '0;
      sizeQ    <= SZ_BYTE;
      signedQ  <= 1'b0;
    end else if (strobes.capture) begin
      selOddQ  <= selOdd;
      byteOffQ <= byteOff;
      sizeQ    <= ldSizeT'(ldSize);
      signedQ  <= ldSigned;
    end
  end

  // late select, byte steering, extension
  logic [DATA_W-1:0] chosen, shifted, extended;

  always_comb begin
    chosen  = selOddQ ? bankQ[1] : bankQ[0];
    shifted = chosen >> {byteOffQ, 3'b000};
    unique case (sizeQ)
      SZ_BYTE: extended = {{(DATA_W-8){signedQ & shifted[7]}},   shifted[7:0]};
      SZ_HALF: extended = {{(DATA_W-16){signedQ & shifted[15]}}, shifted[15:0]};
      SZ_WORD: extended = {{(DATA_W-32){signedQ & shifted[31]}}, shifted[31:0]};
      default: extended = shifted;
    endcase
  end

  assign rdData = strobes.outValid ? extended : '0;

  // R3
  even_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> csMatch(rIdx, oIdx, {evenRow, 1'b0}));
  // R3
  odd_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> csMatch(rIdx, oIdx, {oddRow, 1'b1}));
  // R3
  late_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (selOddQ == $past(vaddr[OFF_W])));
endmodule

// File: rtl/sadCacheRead.sv
module sadCacheRead
  import sadCachePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldBase,
  input  logic [ADDR_W-1:0] ldOffset,
  input  logic [1:0]        ldSize,
  input  logic              ldSigned,
  output logic [ADDR_W-1:0] vaddr,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [DATA_W-1:0] wrData,
  output logic              rdValid,
  output logic              rdMisalign,
  output logic [DATA_W-1:0] rdData
);
  ctrlStrobeT       strobes;
  logic [OFF_W-1:0] byteOff;

  sadCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ldValid   (ldValid),
    .ldSize    (ldSize),
    .byteOff   (byteOff),
    .strobes   (strobes),
    .rdValid   (rdValid),
    .rdMisalign(rdMisalign)
  );

  sadData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ldBase  (ldBase),
    .ldOffset(ldOffset),
    .ldSize  (ldSize),
    .ldSigned(ldSigned),
    .vaddr   (vaddr),
    .byteOff (byteOff),
    .wrEn    (wrEn),
    .wrIndex (wrIndex),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: tb/sadCacheRead_bench.sv
`timescale 1ns/1ps
module sadCacheRead_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldValid = 1'b0;
  logic [31:0] ldBase = '0;
  logic [31:0] ldOffset = '0;
  logic [1:0]  ldSize = '0;
  logic        ldSigned = 1'b0;
  logic [31:0] vaddr;
  logic        wrEn = 1'b0;
  logic [10:0] wrIndex = '0;
  logic [63:0] wrData = '0;
  logic        rdValid, rdMisalign;
  logic [63:0] rdData;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [63:0] model [2048];

  always #2.5 clk = ~clk;

  sadCacheRead u_sadCacheRead (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldBase(ldBase),
    .ldOffset(ldOffset), .ldSize(ldSize), .ldSigned(ldSigned),
    .vaddr(vaddr), .wrEn(wrEn), .wrIndex(wrIndex), .wrData(wrData),
    .rdValid(rdValid), .rdMisalign(rdMisalign), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pattern(input int i);
    logic [31:0] a, b;
    a = 32'(i) * 32'h9E3779B1 ^ 32'hC3A5_0F1E;
    b = 32'(i) * 32'h85EBCA6B ^ 32'h7F80_01FE;
    return {a, b};
  endfunction

  function automatic logic [2:0] maskOf(input logic [1:0] sz);
    return 3'((1 << sz) - 1);
  endfunction

  // R5 R6 R7 model
  function automatic logic [63:0] expLoad(input logic [31:0] a,
                                          input logic [1:0] sz, input bit sg);
    logic [63:0] d;
    d = model[a[13:3]] >> (a[2:0] * 8);
    case (sz)
      2'd0: d = {{56{sg & d[7]}},  d[7:0]};
      2'd1: d = {{48{sg & d[15]}}, d[15:0]};
      2'd2: d = {{32{sg & d[31]}}, d[31:0]};
      default: ;
    endcase
    return d;
  endfunction

  task automatic writeLine(input logic [10:0] idx, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIndex = idx; wrData = d;
    model[idx] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doLoad(input logic [31:0] b, input logic [31:0] o,
                        input logic [1:0] sz, input bit sg, input string req);
    logic [31:0] a;
    bit mis;
    a = b + o;
    mis = (a[2:0] & maskOf(sz)) != 0;
    @(negedge clk);
    ldValid = 1'b1; ldBase = b; ldOffset = o; ldSize = sz; ldSigned = sg;
    #1;
    check(vaddr == a, "R1 vaddr", 64'(vaddr), 64'(a));
    @(negedge clk);
    ldValid = 1'b0;
    if (mis) begin
      check(rdMisalign && !rdValid && rdData == 0, {"R8 ", req},
            {rdValid, rdMisalign, rdData[61:0]}, 64'h4000_0000_0000_0000);
    end else begin
      check(rdValid && !rdMisalign, {"R2 ", req}, {62'd0, rdValid, rdMisalign}, 64'd2);
      check(rdData == expLoad(a, sz, sg), req, rdData, expLoad(a, sz, sg));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R10
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rdValid && !rdMisalign && rdData == 0, "R10 reset",
          {rdValid, rdMisalign, rdData[61:0]}, 64'd0);
    rstN = 1'b1;

    // fill every line through the write port (R9)
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrIndex = 11'(i); wrData = pattern(i);
      model[i] = pattern(i);
    end
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    check(!rdValid && !rdMisalign, "R2 idle", {62'd0, rdValid, rdMisalign}, 64'd0);

    // R3 low carry, index sum even -> odd line
    doLoad(32'h0000_0105, 32'h0000_0003, 2'd0, 1'b0, "R3 carry even-I");
    // R3 low carry, index sum odd -> even line
    doLoad(32'h0000_010D, 32'h0000_0003, 2'd0, 1'b1, "R3 carry odd-I");
    doLoad(32'h0000_0200, 32'h0000_0018, 2'd3, 1'b0, "R3 no carry");
    doLoad(32'h0000_0106, 32'h0000_0006, 2'd2, 1'b1, "R3 carry word");
    // R4 wrap
    doLoad(32'h0000_3FFF, 32'h0000_0001, 2'd3, 1'b0, "R4 wrap via carry");
    doLoad(32'h0000_3FF8, 32'h0000_0010, 2'd1, 1'b1, "R4 wrap no carry");
    doLoad(32'h0000_3FFC, 32'h0000_0004, 2'd2, 1'b0, "R4 last line carry");
    doLoad(32'h0000_0010, 32'hFFFF_FFF8, 2'd3, 1'b0, "R4 negative offset");
    // R5 R6 R7 every byte position and size
    for (int p = 0; p < 8; p++) begin
      doLoad(32'h0000_0A40, 32'(p), 2'd0, 1'b1, "R5 byte signed");
      doLoad(32'h0000_0A40, 32'(p), 2'd0, 1'b0, "R7 byte unsigned");
    end
    doLoad(32'h0000_0A40, 32'd6, 2'd1, 1'b1, "R6 half signed");
    doLoad(32'h0000_0A40, 32'd4, 2'd2, 1'b0, "R6 word unsigned");
    doLoad(32'h0000_0A40, 32'd4, 2'd2, 1'b1, "R7 word signed");
    // R8 misaligned
    doLoad(32'h0000_0A40, 32'd2, 2'd2, 1'b0, "misaligned word");
    doLoad(32'h0000_0A40, 32'd4, 2'd3, 1'b0, "misaligned dbl");
    doLoad(32'h0000_0A41, 32'd0, 2'd1, 1'b1, "misaligned half");
    // R9 overwrite odd line, neighbour keeps its value
    writeLine(11'd5, 64'h8000_0000_FFFF_0081);
    writeLine(11'd6, 64'h0123_4567_89AB_CDEF);
    doLoad(32'h0000_0020, 32'h0000_0008, 2'd3, 1'b0, "R9 written odd line");
    doLoad(32'h0000_0020, 32'h0000_0010, 2'd3, 1'b0, "R9 written even line");
    doLoad(32'h0000_0020, 32'h0000_0000, 2'd3, 1'b0, "R9 untouched line");

    // random pairs
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] b, o, a;
      logic [1:0] sz;
      bit sg;
      b  = $urandom();
      o  = ($urandom_range(3) == 0) ? $urandom() : 32'($signed(16'($urandom())));
      sz = 2'($urandom_range(3));
      sg = 1'($urandom_range(1));
      a  = b + o;
      if ($urandom_range(9) < 8) o = o - 32'(a[2:0] & maskOf(sz));
      doLoad(b, o, sz, sg, "R3 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule